// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block collects up to ninety-six interrupt lines, arranged as three banks of thirty-two, into one interrupt request for a processor. Each line has a pending bit, an enable bit and a block bit. A line drives the request only when it is pending, enabled and not blocked. A vector register gives the number of the lowest-numbered such line, so the interrupt handler can dispatch without scanning the banks itself. Software reaches all of these registers over a plain 32-bit register bus. A write takes effect at the next clock edge, and read data is combinational from the address.

Line 0 is an external input with a selectable trigger: low level, high level, falling edge or rising edge. Its pending bit holds until software clears it with a write of one. Lines 1 to 95 are level inputs, and their pending bits track the synchronised input. The vector encodes the line number shifted left by two. It therefore reads zero both when nothing is active and when line 0 is active, so the handler reads pending bit 0 to tell the two cases apart.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every register reads zero and `irq_o` is low.
- R2: Line n appears at bit n%32 of bank n/32. The pending banks are at byte offsets 0x10, 0x14 and 0x18, the enable banks at 0x40, 0x44 and 0x48, and the block banks at 0x50, 0x54 and 0x58.
- R3: A read of offset 0x00 returns the lowest-numbered line that is pending, enabled and unblocked, in bits [8:2]. Bits [1:0] and [31:9] read zero.
- R4: Offset 0x00 reads zero when no line is active and also when line 0 is the lowest active line; pending bit 0 tells these cases apart.
- R5: For lines 1 to 95, the pending bit equals the input as it was sampled three clock edges earlier (a two-flop synchroniser, then the pending flop). Writes to those pending bits have no effect.
- R6: Bits [1:0] at offset 0x0C select the trigger for line 0: 0 is low level, 1 is high level, 2 is falling edge and 3 is rising edge. Edges are detected on the synchronised input.
- R7: Once set, pending bit 0 holds until a write to 0x10 with bit 0 set. A write of 0 to that bit changes nothing. In a level mode, the clear does not hold while the input is still active.
- R8: `irq_o` is high exactly when at least one line is pending, enabled and unblocked. A block bit of 1 or an enable bit of 0 removes that line.
- R9: The enable and block banks are 32-bit read/write registers. Offset 0x08 holds one read/write bit in bit 0. Offset 0x0C holds two read/write bits in [1:0]. All other bits of these registers read zero.
- R10: Offsets 0x20 to 0x28, every other unmapped offset, and every address that is not word-aligned read zero. Writes to these addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 96 | Interrupt lines; bit 0 is the external line |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted pending, enable or block bit appears on `irq_o` and on the vector read in the same cycle that the bad state is first held. A stale synchroniser stage or a wrong trigger decode shows up one edge late or early in the pending bank reads. The bench compares both outputs against a behavioural model on every cycle, under directed sequences and a long random phase, so a divergence is reported at the first cycle it reaches the ports. Writes to the decode holes are followed straight away by reads of every register, which exposes any stray write.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

    localparam int ADDR_W       = 8;
    localparam int DEF_BANKS    = 3;
    localparam int DEF_BANK_W   = 32;

    // Byte offsets of the register groups
    localparam logic [ADDR_W-1:0] OFF_VECTOR = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_GUARD  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_EXTCFG = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_ENA    = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_BLOCK  = 8'h50;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } ext_trig_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_VECTOR,
        RG_GUARD,
        RG_EXTCFG,
        RG_PEND,
        RG_ENA,
        RG_BLOCK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  bank;
    } reg_sel_t;

    // Address decode: word-aligned only, bank index limited to the banks built
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned nbanks);
        reg_sel_t s;
        logic     bank_ok;
        s.kind  = RG_NONE;
        s.bank  = a[3:2];
        bank_ok = (int'(a[3:2]) < int'(nbanks));
        if (a[1:0] == 2'b00) begin
            case (a[7:4])
                4'h0: begin
                    if (a[3:2] == 2'd0)      s.kind = RG_VECTOR;
                    else if (a[3:2] == 2'd2) s.kind = RG_GUARD;
                    else if (a[3:2] == 2'd3) s.kind = RG_EXTCFG;
                end
                4'h1: if (bank_ok) s.kind = RG_PEND;
                4'h4: if (bank_ok) s.kind = RG_ENA;
                4'h5: if (bank_ok) s.kind = RG_BLOCK;
                default: s.kind = RG_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic         prev0_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic         last0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            last0_q  <= 1'b0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
            last0_q  <= stage2_q[0];
        end
    end

    assign sync_o  = stage2_q;
    assign prev0_o = last0_q;

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int BANK_W  = 32,
    parameter bit HAS_EXT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] sync_i,
    input  logic              ext_hit_i,
    input  logic              wr_pend_i,
    input  logic              wr_ena_i,
    input  logic              wr_block_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] pend_o,
    output logic [BANK_W-1:0] ena_o,
    output logic [BANK_W-1:0] block_o
);

    logic [BANK_W-1:0] pend_q;
    logic [BANK_W-1:0] ena_q;
    logic [BANK_W-1:0] block_q;
    logic [BANK_W-1:0] pend_d;
    logic              clr0;

    assign clr0 = wr_pend_i & wdata_i[0];

    // Level lines follow the synchronised input; the external line latches
    always_comb begin
        pend_d    = sync_i;
        pend_d[0] = HAS_EXT ? (ext_hit_i | (pend_q[0] & ~clr0)) : sync_i[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            ena_q   <= '0;
            block_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (wr_ena_i)   ena_q   <= wdata_i;
            if (wr_block_i) block_q <= wdata_i;
        end
    end

    assign pend_o  = pend_q;
    assign ena_o   = ena_q;
    assign block_o = block_q;

endmodule

// File: rtl/irq_lowest_find.sv
module irq_lowest_find #(
    parameter int N     = 96,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             found_o
);

    // Scan from the top so the lowest set bit is the last one written
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o   = IDX_W'(i);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vector_pkg::*;
#(
    parameter int NUM_BANKS = DEF_BANKS,
    parameter int BANK_W    = DEF_BANK_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BANKS*BANK_W-1:0] src_in,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic                        irq_o
);

    localparam int NUM_SRC   = NUM_BANKS * BANK_W;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);

    // Input synchronisation
    logic [NUM_SRC-1:0] sync_q;
    logic               prev0_q;

    irq_src_sync #(.W(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (src_in),
        .sync_o  (sync_q),
        .prev0_o (prev0_q)
    );

    // Register decode
    reg_sel_t sel;
    assign sel = decode_addr(bus_addr, NUM_BANKS);

    // Global configuration registers
    logic       prot_q;
    logic [1:0] extcfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q   <= 1'b0;
            extcfg_q <= 2'b00;
        end else begin
            if (bus_we && sel.kind == RG_GUARD)  prot_q   <= bus_wdata[0];
            if (bus_we && sel.kind == RG_EXTCFG) extcfg_q <= bus_wdata[1:0];
        end
    end

    // Trigger detection for the external line
    ext_trig_e trig;
    logic      ext_hit;

    assign trig = ext_trig_e'(extcfg_q);

    always_comb begin
        unique case (trig)
            TRIG_LOW:  ext_hit = ~sync_q[0];
            TRIG_HIGH: ext_hit =  sync_q[0];
            TRIG_FALL: ext_hit =  prev0_q & ~sync_q[0];
            TRIG_RISE: ext_hit = ~prev0_q &  sync_q[0];
            default:   ext_hit = 1'b0;
        endcase
    end

    // Per-bank state
    logic [NUM_BANKS-1:0][BANK_W-1:0] pend_bk;
    logic [NUM_BANKS-1:0][BANK_W-1:0] ena_bk;
    logic [NUM_BANKS-1:0][BANK_W-1:0] blk_bk;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_bank;
        assign hit_bank = (sel.bank == 2'(b));

        irq_pend_bank #(
            .BANK_W  (BANK_W),
            .HAS_EXT (b == 0)
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .sync_i     (sync_q[b*BANK_W +: BANK_W]),
            .ext_hit_i  (ext_hit),
            .wr_pend_i  (bus_we && sel.kind == RG_PEND  && hit_bank),
            .wr_ena_i   (bus_we && sel.kind == RG_ENA   && hit_bank),
            .wr_block_i (bus_we && sel.kind == RG_BLOCK && hit_bank),
            .wdata_i    (bus_wdata),
            .pend_o     (pend_bk[b]),
            .ena_o      (ena_bk[b]),
            .block_o    (blk_bk[b])
        );
    end

    // Flattened views and active set
    logic [NUM_SRC-1:0] pend_flat;
    logic [NUM_SRC-1:0] ena_flat;
    logic [NUM_SRC-1:0] blk_flat;
    logic [NUM_SRC-1:0] act_flat;

    assign pend_flat = pend_bk;
    assign ena_flat  = ena_bk;
    assign blk_flat  = blk_bk;
    assign act_flat  = pend_flat & ena_flat & ~blk_flat;

    // Lowest active line
    logic [SRC_IDX_W-1:0] win_idx;
    logic                 win_found;

    irq_lowest_find #(.N(NUM_SRC), .IDX_W(SRC_IDX_W)) u_find (
        .req_i   (act_flat),
        .idx_o   (win_idx),
        .found_o (win_found)
    );

    assign irq_o = win_found;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        unique case (sel.kind)
            RG_VECTOR: if (win_found) bus_rdata[SRC_IDX_W+1:2] = win_idx;
            RG_GUARD:  bus_rdata[0]   = prot_q;
            RG_EXTCFG: bus_rdata[1:0] = extcfg_q;
            RG_PEND: begin
                for (int b = 0; b < NUM_BANKS; b++)
                    if (sel.bank == 2'(b)) bus_rdata = pend_bk[b];
            end
            RG_ENA: begin
                for (int b = 0; b < NUM_BANKS; b++)
                    if (sel.bank == 2'(b)) bus_rdata = ena_bk[b];
            end
            RG_BLOCK: begin
                for (int b = 0; b < NUM_BANKS; b++)
                    if (sel.bank == 2'(b)) bus_rdata = blk_bk[b];
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import irq_vector_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int BANK_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [BANK_W-1:0]  bus_wdata,
    input logic [BANK_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_flat,
    input logic [NUM_SRC-1:0] act_flat,
    input logic [NUM_SRC-1:0] sync_q,
    input logic               prot_q
);

    localparam int SRC_IDX_W = $clog2(NUM_SRC);

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_o && pend_flat == '0));

    // R3
    vec_field_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_VECTOR) |->
            (bus_rdata[1:0] == 2'b00 && bus_rdata[BANK_W-1:SRC_IDX_W+2] == '0));

    // R4
    vec_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_VECTOR && bus_rdata == '0 && irq_o) |-> act_flat[0]);

    // R5
    lvl_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pend_flat[1] |-> $past(sync_q[1]));

    // R7
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_flat[0] && !(bus_we && bus_addr == OFF_PEND && bus_wdata[0]))
            |=> pend_flat[0]);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (act_flat != '0));

    // R9
    guard_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_GUARD) |=> (prot_q == $past(bus_wdata[0])));

    // R10
    fiq_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[7:4] == 4'h2) |-> (bus_rdata == '0));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .BANK_W  (BANK_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .pend_flat (pend_flat),
    .act_flat  (act_flat),
    .sync_q    (sync_q),
    .prot_q    (prot_q)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [95:0] src_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b1;

    always #4 clk = ~clk;   // 125 MHz

    irq_vector_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src_in),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Behavioural reference model, advanced on each rising edge
    bit [95:0] m_s1, m_s2, m_pend, m_en, m_mask;
    bit        m_s3, m_prot;
    bit [1:0]  m_cfg;

    always @(posedge clk) begin
        bit [95:0] np;
        bit        hit;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_s3 = 0;
            m_pend = '0; m_en = '0; m_mask = '0;
            m_prot = 0; m_cfg = 0;
        end else begin
            case (m_cfg)
                2'd0:    hit = !m_s2[0];
                2'd1:    hit = m_s2[0];
                2'd2:    hit = m_s3 && !m_s2[0];
                default: hit = !m_s3 && m_s2[0];
            endcase
            np    = m_s2;
            np[0] = hit || (m_pend[0] && !(bus_we && bus_addr == 8'h10 && bus_wdata[0]));
            if (bus_we) begin
                case (bus_addr)
                    8'h08: m_prot = bus_wdata[0];
                    8'h0C: m_cfg  = bus_wdata[1:0];
                    8'h40: m_en[31:0]    = bus_wdata;
                    8'h44: m_en[63:32]   = bus_wdata;
                    8'h48: m_en[95:64]   = bus_wdata;
                    8'h50: m_mask[31:0]  = bus_wdata;
                    8'h54: m_mask[63:32] = bus_wdata;
                    8'h58: m_mask[95:64] = bus_wdata;
                    default: ;
                endcase
            end
            m_pend = np;
            m_s3   = m_s2[0];
            m_s2   = m_s1;
            m_s1   = src_in;
        end
    end

    function automatic bit [31:0] exp_read(input bit [7:0] a);
        bit [95:0] act;
        act = m_pend & m_en & ~m_mask;
        case (a)
            8'h00: begin
                for (int i = 0; i < 96; i++)
                    if (act[i]) return 32'(i) << 2;
                return 32'd0;
            end
            8'h08: return {31'd0, m_prot};
            8'h0C: return {30'd0, m_cfg};
            8'h10: return m_pend[31:0];
            8'h14: return m_pend[63:32];
            8'h18: return m_pend[95:64];
            8'h40: return m_en[31:0];
            8'h44: return m_en[63:32];
            8'h48: return m_en[95:64];
            8'h50: return m_mask[31:0];
            8'h54: return m_mask[63:32];
            8'h58: return m_mask[95:64];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input bit [7:0] a);
        if (a == 8'h00) return "R3 R4";
        if (a == 8'h08 || a == 8'h0C) return "R9";
        if (a == 8'h10 || a == 8'h14 || a == 8'h18) return "R2 R5 R6 R7";
        if (a == 8'h40 || a == 8'h44 || a == 8'h48 ||
            a == 8'h50 || a == 8'h54 || a == 8'h58) return "R2 R9";
        return "R10";
    endfunction

    // Compare on every falling edge
    always @(negedge clk) begin
        if (running) begin
            bit [31:0] er;
            bit        ei;
            er = exp_read(bus_addr);
            ei = |(m_pend & m_en & ~m_mask);
            checks += 2;
            if (irq_o !== ei) begin
                fails++;
                $display("FAIL %s irq_o actual=%b expected=%b t=%0t",
                         rst ? "R1" : "R8", irq_o, ei, $time);
            end
            if (bus_rdata !== er) begin
                fails++;
                $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t",
                         rst ? "R1" : tag_of(bus_addr), bus_addr, bus_rdata, er, $time);
            end
        end
    end

    localparam bit [7:0] SCAN [22] = '{
        8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28,
        8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h60, 8'hFC, 8'h11};

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic scan();
        foreach (SCAN[i]) begin
            @(posedge clk); #1;
            bus_addr = SCAN[i];
        end
        step(1);
    endtask

    task automatic show(input bit [7:0] a, input int n);
        @(posedge clk); #1;
        bus_addr = a;
        step(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit [31:0] lfsr;
        // R1: reset state across every register
        foreach (SCAN[i]) begin
            @(posedge clk); #1;
            bus_addr = SCAN[i];
        end
        rst = 1'b0;
        scan();

        // R6 R7: high-level trigger, then acknowledge the pending bit
        wr(8'h0C, 32'h1);
        wr(8'h10, 32'h1);
        scan();

        // R9 R2: open every enable
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h48, 32'hFFFF_FFFF);
        src_in[5] = 1; src_in[40] = 1; src_in[70] = 1;
        show(8'h00, 4);          // R3: vector = 5<<2
        scan();

        // R5: writes to level pending bits have no effect
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        show(8'h14, 2);
        src_in[5] = 0;
        show(8'h00, 4);          // R3: vector = 40<<2

        // R8: block bits
        wr(8'h54, 32'h0000_0100);
        show(8'h00, 2);          // vector = 70<<2
        wr(8'h58, 32'hFFFF_FFFF);
        show(8'h00, 2);          // irq low
        wr(8'h54, 32'h0);
        wr(8'h58, 32'h0);
        wr(8'h44, 32'h0);
        wr(8'h48, 32'h0);
        src_in[40] = 0; src_in[70] = 0;
        scan();

        // R6 R4: rising edge on line 0
        wr(8'h0C, 32'h3);
        wr(8'h10, 32'h1);
        src_in[0] = 1;
        show(8'h00, 5);          // irq high, vector reads zero
        src_in[0] = 0;
        wr(8'h10, 32'h0);        // R7: write 0 keeps it
        show(8'h10, 2);
        wr(8'h10, 32'h1);        // R7: write 1 clears it
        show(8'h10, 2);

        // R6: falling edge
        wr(8'h0C, 32'h2);
        src_in[0] = 1;
        show(8'h10, 4);
        src_in[0] = 0;
        show(8'h00, 4);
        wr(8'h10, 32'h1);

        // R7: low level with the input still low, clear does not hold
        wr(8'h0C, 32'h0);
        show(8'h10, 3);
        wr(8'h10, 32'h1);
        show(8'h10, 2);
        src_in[0] = 1;
        step(4);
        wr(8'h10, 32'h1);
        show(8'h10, 2);

        // R10 R9: stray writes and the guard bit
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h5C, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h41, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        scan();

        // Random phase
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk); #1;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            bus_we    = (lfsr[3:0] == 4'd0);
            bus_addr  = SCAN[int'(lfsr[9:4]) % 22];
            bus_wdata = {lfsr[15:0], lfsr[31:16]} ^ {lfsr[7:0], lfsr[31:8]};
            if (lfsr[13:11] == 3'd0) begin
                int idx;
                idx = int'(lfsr[24:14]) % 96;
                src_in[idx] = ~src_in[idx];
            end
        end
        bus_we = 1'b0;
        scan();

        running = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule